// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block is the register front end of a shared-memory signalling device. A host reaches it over a simple 32-bit register bus inside a 256-byte window. It holds a mask word and a cause word, and it raises a level interrupt whenever the two share a set bit. A read-only word reports the node's own peer number once the shared region is mapped.

A write to the doorbell word asks for a notification to a remote peer on one of that peer's vectors. The block checks the request against the live peer count and a per-peer table of registered vector counts. Only a request that passes both checks leaves as a one-cycle notify pulse. A local event input with a byte payload overwrites the cause word, so remote peers can interrupt this node.

Top module: `doorbell_regblk`

## Requirements
- R1: The read offsets are mask at 0x00, cause at 0x04 and identity at 0x08. Reads decode the full 8-bit address exactly. Read data appears on `bus_rdata` in the cycle after the read strobe and is zero in every cycle that does not follow a read.
- R2: A read of 0x08 returns `node_id` zero-extended to 32 bits when `region_mapped` is 1. When `region_mapped` is 0 it returns 0xFFFFFFFF.
- R3: `irq` is 1 exactly when the bitwise AND of the mask and cause words is non-zero. It follows every change to either word in the same cycle as the register update, which is one clock after the write or event.
- R4: A read of the cause word returns its value before the read and leaves the word at zero afterwards.
- R5: A write to the mask or the cause word replaces the whole word. Writes decode only address bits 7:2, so for example 0x05 writes the cause word.
- R6: A write whose address bits 7:2 equal 3 (0x0C) is a doorbell request. It takes the destination from data bits 31:16 and the vector from bits 7:0, and it ignores bits 15:8. An accepted request raises `ring_valid` for exactly one cycle, the cycle after the write, with `ring_peer` and `ring_vector` set to the request's destination and vector.
- R7: A doorbell request is dropped with no pulse when its destination is at or above `peer_count`, or at or above the table size MAX_PEERS.
- R8: A doorbell request is dropped when its vector is at or above the vector count registered for the destination. Peer i's count occupies bits 8*i+7 down to 8*i of `peer_vec_cnt`.
- R9: Reads of 0x0C and of every other offset not named in R1 return zero. Writes to the identity word and to undefined offsets change nothing.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears the mask and cause words. After it, `irq`, `ring_valid` and `bus_rdata` are 0.
- R11: A cycle with `evt_valid` high loads `evt_byte`, zero-extended, into the cause word.
- R12: When an event arrives in the same cycle as a cause read or a cause write, the event value is what the cause word holds afterwards. The same-cycle read still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| node_id | input | 16 | This node's peer number |
| region_mapped | input | 1 | Shared region is mapped |
| peer_count | input | 16 | Number of known peers |
| peer_vec_cnt | input | MAX_PEERS*8 | Registered vector count per peer, 8 bits each |
| evt_valid | input | 1 | Local event strobe |
| evt_byte | input | 8 | Local event payload |
| ring_valid | output | 1 | Notify pulse |
| ring_peer | output | 16 | Destination peer of the notify |
| ring_vector | output | 8 | Vector of the notify |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due one clock after its stimulus. Read data, the notify pulse and the register updates behind `irq` are each one register stage from the strobe or event. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples at that second falling edge, which is half a period after the single rising edge that produces the result. A full sweep of destination against vector, under two peer counts, compares every pulse with an acceptance rule the bench computes itself. The ordering cases (event against read and against write, and writes at unaligned addresses) are each driven in one cycle and checked the same way.

// File: rtl/db_regblk_pkg.sv
package db_regblk_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned WIN_AW = 8;
    localparam int unsigned PEER_W = 16;
    localparam int unsigned VEC_W  = 8;

    // Word index (address bits 7:2); the doorbell index is fixed by the bus map.
    localparam logic [WIN_AW-3:0] WORD_MASK = 6'd0;
    localparam logic [WIN_AW-3:0] WORD_CAUSE = 6'd1;
    localparam logic [WIN_AW-3:0] WORD_RING = 6'd3;

    localparam logic [WIN_AW-1:0] OFS_MASK  = 8'h00;
    localparam logic [WIN_AW-1:0] OFS_CAUSE = 8'h04;
    localparam logic [WIN_AW-1:0] OFS_ID    = 8'h08;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] cause;
    } intr_state_t;

    typedef struct packed {
        logic              valid;
        logic [PEER_W-1:0] peer;
        logic [VEC_W-1:0]  vector;
    } ring_state_t;
endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode
    import db_regblk_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [WIN_AW-1:0] addr,
    output logic              wr_mask,
    output logic              wr_cause,
    output logic              wr_ring,
    output logic              rd_mask,
    output logic              rd_cause,
    output logic              rd_id
);
    logic              is_wr;
    logic              is_rd;
    logic [WIN_AW-3:0] word;

    always_comb begin
        is_wr    = sel && wr;
        is_rd    = sel && !wr;
        word     = addr[WIN_AW-1:2];
        // writes use the word index only; low address bits are dropped
        wr_mask  = is_wr && (word == WORD_MASK);
        wr_cause = is_wr && (word == WORD_CAUSE);
        wr_ring  = is_wr && (word == WORD_RING);
        // reads compare the whole byte offset
        rd_mask  = is_rd && (addr == OFS_MASK);
        rd_cause = is_rd && (addr == OFS_CAUSE);
        rd_id    = is_rd && (addr == OFS_ID);
    end
endmodule

// File: rtl/db_intr_regs.sv
module db_intr_regs
    import db_regblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic             wr_cause,
    input  logic             rd_cause,
    input  logic [REG_W-1:0] wdata,
    input  logic             evt_valid,
    input  logic [7:0]       evt_byte,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] cause_q,
    output logic             irq
);
    intr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask) begin
            st_d.mask = wdata;
        end
        // a local event outranks any bus action on the cause word
        if (evt_valid) begin
            st_d.cause = {{(REG_W-8){1'b0}}, evt_byte};
        end else if (wr_cause) begin
            st_d.cause = wdata;
        end else if (rd_cause) begin
            st_d.cause = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign cause_q = st_q.cause;
    assign irq     = |(st_q.cause & st_q.mask);
endmodule

// File: rtl/db_ring_gate.sv
module db_ring_gate
    import db_regblk_pkg::*;
#(
    parameter int unsigned MAX_PEERS = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fire,
    input  logic [REG_W-1:0]             wdata,
    input  logic [PEER_W-1:0]            peer_count,
    input  logic [MAX_PEERS*CNT_W-1:0]   peer_vec_cnt,
    output logic                         ring_valid,
    output logic [PEER_W-1:0]            ring_peer,
    output logic [VEC_W-1:0]             ring_vector
);
    localparam int unsigned IDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1;

    logic [CNT_W-1:0]  cnt_tbl [MAX_PEERS];
    logic [PEER_W-1:0] dest;
    logic [VEC_W-1:0]  vec;
    logic [CNT_W-1:0]  dest_cnt;
    logic              in_table;
    logic              below_count;
    logic              vec_ok;
    ring_state_t       rg_d, rg_q;

    for (genvar i = 0; i < MAX_PEERS; i++) begin : g_tbl
        assign cnt_tbl[i] = peer_vec_cnt[i*CNT_W +: CNT_W];
    end

    always_comb begin
        dest        = wdata[31:16];
        vec         = wdata[VEC_W-1:0];
        in_table    = 32'(dest) < MAX_PEERS;
        below_count = dest < peer_count;
        dest_cnt    = in_table ? cnt_tbl[IDX_W'(dest)] : '0;
        vec_ok      = 32'(vec) < 32'(dest_cnt);

        rg_d       = rg_q;
        rg_d.valid = fire && in_table && below_count && vec_ok;
        if (rg_d.valid) begin
            rg_d.peer   = dest;
            rg_d.vector = vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ring_valid  = rg_q.valid;
    assign ring_peer   = rg_q.peer;
    assign ring_vector = rg_q.vector;
endmodule

// File: rtl/doorbell_regblk.sv
module doorbell_regblk
    import db_regblk_pkg::*;
#(
    parameter int unsigned MAX_PEERS = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [15:0]                node_id,
    input  logic                       region_mapped,
    input  logic [15:0]                peer_count,
    input  logic [MAX_PEERS*CNT_W-1:0] peer_vec_cnt,
    input  logic                       evt_valid,
    input  logic [7:0]                 evt_byte,
    output logic                       ring_valid,
    output logic [15:0]                ring_peer,
    output logic [7:0]                 ring_vector,
    output logic                       irq
);
    logic             wr_mask, wr_cause, wr_ring;
    logic             rd_mask, rd_cause, rd_id;
    logic [REG_W-1:0] mask_q, cause_q;
    logic [REG_W-1:0] rdata_d, rdata_q;

    db_addr_decode u_dec (
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wr_mask  (wr_mask),
        .wr_cause (wr_cause),
        .wr_ring  (wr_ring),
        .rd_mask  (rd_mask),
        .rd_cause (rd_cause),
        .rd_id    (rd_id)
    );

    db_intr_regs u_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_cause  (wr_cause),
        .rd_cause  (rd_cause),
        .wdata     (bus_wdata),
        .evt_valid (evt_valid),
        .evt_byte  (evt_byte),
        .mask_q    (mask_q),
        .cause_q   (cause_q),
        .irq       (irq)
    );

    db_ring_gate #(
        .MAX_PEERS (MAX_PEERS),
        .CNT_W     (CNT_W)
    ) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (wr_ring),
        .wdata        (bus_wdata),
        .peer_count   (peer_count),
        .peer_vec_cnt (peer_vec_cnt),
        .ring_valid   (ring_valid),
        .ring_peer    (ring_peer),
        .ring_vector  (ring_vector)
    );

    always_comb begin
        rdata_d = '0;
        if (rd_mask) begin
            rdata_d = mask_q;
        end else if (rd_cause) begin
            rdata_d = cause_q;  // value before the clear
        end else if (rd_id) begin
            rdata_d = region_mapped ? {{(REG_W-PEER_W){1'b0}}, node_id} : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/db_regblk_chk.sv
module db_regblk_chk #(
    parameter int unsigned MAX_PEERS = 16,
    parameter int unsigned CNT_W     = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [7:0]                 bus_addr,
    input logic [31:0]                bus_rdata,
    input logic                       region_mapped,
    input logic [15:0]                peer_count,
    input logic [MAX_PEERS*CNT_W-1:0] peer_vec_cnt,
    input logic                       evt_valid,
    input logic                       ring_valid,
    input logic [15:0]                ring_peer,
    input logic [7:0]                 ring_vector,
    input logic                       irq
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    logic undef_rd;
    assign undef_rd = bus_sel && !bus_wr && bus_addr != 8'h00
                      && bus_addr != 8'h04 && bus_addr != 8'h08;

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!irq && !ring_valid && bus_rdata == 32'd0));

    a_r6_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ring_valid) |-> $past(bus_sel && bus_wr && bus_addr[7:2] == 6'd3));

    a_r7_dest_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ring_valid) |-> (32'(ring_peer) < MAX_PEERS && ring_peer < $past(peer_count)));

    a_r8_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ring_valid && 32'(ring_peer) < MAX_PEERS)
        |-> (32'(ring_vector) < 32'(peer_vec_cnt[32'(ring_peer)*CNT_W +: CNT_W])));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(bus_sel && !bus_wr && bus_addr == 8'h04 && !evt_valid)) |-> !irq);

    a_r2_unmapped_id: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(bus_sel && !bus_wr && bus_addr == 8'h08 && !region_mapped))
        |-> bus_rdata == 32'hFFFF_FFFF);

    a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(undef_rd)) |-> bus_rdata == 32'd0);
endmodule

bind doorbell_regblk db_regblk_chk #(
    .MAX_PEERS (MAX_PEERS),
    .CNT_W     (CNT_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .region_mapped (region_mapped),
    .peer_count    (peer_count),
    .peer_vec_cnt  (peer_vec_cnt),
    .evt_valid     (evt_valid),
    .ring_valid    (ring_valid),
    .ring_peer     (ring_peer),
    .ring_vector   (ring_vector),
    .irq           (irq)
);

// File: tb/test_doorbell_regblk.sv
`timescale 1ns/1ps
module test_doorbell_regblk;
    localparam int NP = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [15:0]   node_id = 16'h0007;
    logic          region_mapped = 1'b1;
    logic [15:0]   peer_count = 16'd5;
    logic [NP*CW-1:0] peer_vec_cnt;
    logic          evt_valid = 1'b0;
    logic [7:0]    evt_byte = '0;
    logic          ring_valid;
    logic [15:0]   ring_peer;
    logic [7:0]    ring_vector;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    doorbell_regblk #(.MAX_PEERS(NP), .CNT_W(CW)) i_doorbell_regblk (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .node_id(node_id), .region_mapped(region_mapped),
        .peer_count(peer_count), .peer_vec_cnt(peer_vec_cnt),
        .evt_valid(evt_valid), .evt_byte(evt_byte),
        .ring_valid(ring_valid), .ring_peer(ring_peer),
        .ring_vector(ring_vector), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic event_in(input logic [7:0] b);
        @(negedge clk);
        evt_valid = 1'b1; evt_byte = b;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < NP; i++) peer_vec_cnt[i*CW +: CW] = CW'(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 irq after reset", {31'd0, irq}, 32'd0);
        chk("R10 ring_valid after reset", {31'd0, ring_valid}, 32'd0);
        chk("R10 rdata after reset", bus_rdata, 32'd0);
        bus_read(8'h00, rd); chk("R10 mask cleared", rd, 32'd0);
        bus_read(8'h04, rd); chk("R10 cause cleared", rd, 32'd0);

        // R5 / R1: full-word writes, low address bits ignored on writes
        bus_write(8'h00, 32'hA5A5_0F0F);
        bus_read(8'h00, rd); chk("R1 R5 mask readback", rd, 32'hA5A5_0F0F);
        bus_write(8'h05, 32'h0000_0003);
        chk("R3 irq after cause write", {31'd0, irq}, 32'd1);
        bus_read(8'h04, rd); chk("R4 R5 cause readback", rd, 32'h3);
        chk("R4 irq low after clear", {31'd0, irq}, 32'd0);
        bus_read(8'h04, rd); chk("R4 cause now zero", rd, 32'd0);
        @(negedge clk);
        chk("R1 rdata zero when idle", bus_rdata, 32'd0);

        // R9: zero reads, exact read decode
        bus_read(8'h01, rd); chk("R9 R1 unaligned read zero", rd, 32'd0);
        bus_read(8'h0C, rd); chk("R9 doorbell read zero", rd, 32'd0);
        bus_read(8'h40, rd); chk("R9 undefined read zero", rd, 32'd0);

        // R2 identity
        bus_write(8'h08, 32'h1234_5678);
        bus_read(8'h08, rd); chk("R2 R9 id mapped", rd, 32'h0000_0007);
        region_mapped = 1'b0;
        bus_read(8'h08, rd); chk("R2 id unmapped", rd, 32'hFFFF_FFFF);
        region_mapped = 1'b1;
        bus_write(8'h10, 32'hDEAD_BEEF);
        bus_read(8'h00, rd); chk("R9 undefined write no effect", rd, 32'hA5A5_0F0F);

        // R11 / R3 events
        bus_write(8'h00, 32'h0000_00FF);
        event_in(8'h80);
        chk("R11 irq from event", {31'd0, irq}, 32'd1);
        bus_read(8'h04, rd); chk("R11 cause zero-extended byte", rd, 32'h80);
        bus_write(8'h00, 32'h0000_000F);
        event_in(8'h80);
        chk("R3 masked event no irq", {31'd0, irq}, 32'd0);
        bus_read(8'h04, rd); chk("R11 masked event stored", rd, 32'h80);

        // R12 event against read
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h04;
        evt_valid = 1'b1; evt_byte = 8'h21;
        @(negedge clk);
        bus_sel = 1'b0; evt_valid = 1'b0;
        chk("R12 read returns old value", bus_rdata, 32'd0);
        chk("R12 R3 irq with event bit", {31'd0, irq}, 32'd1);
        bus_read(8'h04, rd); chk("R12 event survives read", rd, 32'h21);
        // R12 event against write
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hFFFF_0000;
        evt_valid = 1'b1; evt_byte = 8'h21;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_valid = 1'b0;
        bus_write(8'h00, 32'd0);
        chk("R3 mask clear drops irq", {31'd0, irq}, 32'd0);
        bus_read(8'h04, rd); chk("R12 event beats write", rd, 32'h21);

        // R6 / R7 / R8 sweep
        for (int p = 0; p < 2; p++) begin
            peer_count = (p == 0) ? 16'd5 : 16'd20;
            for (int d = 0; d < 18; d++) begin
                for (int v = 0; v < 10; v++) begin
                    bit ok;
                    ok = (d < int'(peer_count)) && (d < NP) && (v < d);
                    bus_write(8'h0C, {16'(d), 8'h5A, 8'(v)});
                    chk($sformatf("R6 R7 R8 pulse pc=%0d d=%0d v=%0d", peer_count, d, v),
                        {31'd0, ring_valid}, {31'd0, ok});
                    if (ok) begin
                        chk("R6 peer field", {16'd0, ring_peer}, 32'(d));
                        chk("R6 vector field", {24'd0, ring_vector}, 32'(v));
                    end
                end
            end
        end
        bus_write(8'h0C, {16'd3, 8'h00, 8'd2});
        chk("R6 pulse accepted", {31'd0, ring_valid}, 32'd1);
        @(negedge clk);
        chk("R6 pulse lasts one cycle", {31'd0, ring_valid}, 32'd0);

        finish_run();
    end
endmodule